// File: doc/BRIEF.md
# Per-Output Interrupt Mask Router

This block steers two families of interrupt sources to a small set of processor interrupt lines. One family is a vector of timer status bits produced elsewhere. The other is a vector of hardware interrupt inputs. Every output line owns two mask registers: one for the timer family and one for the hardware family. An output rises whenever any source that its masks let through is active.

Software reaches the masks through a simple word-addressed register port. The word address is `{code, line}`, with the three-bit register code in the upper bits and the output line number in the low bits. The timer mask can be replaced outright, or changed one bit group at a time through two write-only aliases. One alias ORs bits in and the other strips them out, so no read-modify-write sequence is needed. A read-only view returns the timer sources that are both active and unmasked for a chosen line. Read data is registered and appears in the cycle after the read strobe.

Top module: `irq_mask_router`

## Requirements
- R1: While `rst` is high at a clock edge, every mask is cleared. After reset every `irq` bit is low whatever the inputs are, and `rdata` is zero.
- R2: Code 0 is the timer mask. A write replaces it with the low `N_TMR` bits of `wdata` and drops the higher bits. A read returns it zero-extended to `DATA_W`.
- R3: A write to code 1 ORs the low `N_TMR` bits of `wdata` into the addressed timer mask and leaves every other bit as it was.
- R4: A write to code 2 clears in the addressed timer mask each bit that is one in `wdata` and leaves the other bits unchanged.
- R5: A read of code 1 or code 2 returns zero.
- R6: A read of code 3 returns `tmr_stat` ANDed with the addressed timer mask, using the status seen at the read edge. A write to code 3 changes no mask.
- R7: Code 4 is the hardware mask, which is read and written directly using the low `N_HW` bits. A write to it leaves the timer mask unchanged.
- R8: `irq[k]` is high exactly when `tmr_stat & tmask[k]` or `hw_irq & hmask[k]` has any bit set. It follows the inputs combinationally.
- R9: A mask write reaches `irq` only after the clock edge that accepts it.
- R10: `rdata` is loaded at each edge. It holds the selected value when `rd_en` was high and zero otherwise. Codes 5 to 7 and line numbers at or above `N_OUT` read as zero, and writes to them are ignored.
- R11: When a read and a write hit the same register in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| rd_en | input | 1 | Read strobe; data appears one cycle later |
| addr | input | 3+IDX_W | Upper 3 bits: register code; low IDX_W bits: output line |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| tmr_stat | input | N_TMR | Timer status vector |
| hw_irq | input | N_HW | Hardware interrupt inputs |
| irq | output | N_OUT | Interrupt lines to the processors |

## Verification
The bench builds the router with 12 timer sources, 5 hardware sources, 3 output lines and a 16-bit data bus. With these values, mask writes carry bits above both source widths, which exercises the truncation of R2. Because three lines need a two-bit line field, line number 3 is a real address that has no line behind it, which brings the ignored-write and zero-read paths of R10 within reach. Random masks and inputs then cover overlapping timer and hardware sources on several lines at once.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  // register codes carried in the upper three address bits
  typedef enum logic [2:0] {
    FN_TMASK = 3'd0,
    FN_TSET  = 3'd1,
    FN_TCLR  = 3'd2,
    FN_TACT  = 3'd3,
    FN_HMASK = 3'd4
  } reg_fn_e;

  localparam int FN_W = 3;
endpackage

// File: rtl/irqr_mask_bank.sv
module irqr_mask_bank
  import irqr_pkg::*;
#(
  parameter int N_TMR = 8,
  parameter int N_HW  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_sel,
  input  logic [FN_W-1:0]  fn,
  input  logic [N_TMR-1:0] wt,
  input  logic [N_HW-1:0]  wh,
  output logic [N_TMR-1:0] tmask,
  output logic [N_HW-1:0]  hmask
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tmask <= '0;
      hmask <= '0;
    end else if (wr_sel) begin
      case (fn)
        FN_TMASK: tmask <= wt;
        FN_TSET:  tmask <= tmask | wt;
        FN_TCLR:  tmask <= tmask & ~wt;
        FN_HMASK: hmask <= wh;
        default:  ;
      endcase
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (tmask == '0 && hmask == '0));

  p_set_keeps_bits_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_sel && fn == FN_TSET) |=> ((tmask & $past(tmask)) == $past(tmask)));

  p_clear_adds_none_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_sel && fn == FN_TCLR) |=> ((tmask & ~$past(tmask)) == '0));

  p_hw_write_isolated_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_sel && fn == FN_HMASK) |=> $stable(tmask));

  p_idle_holds_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_sel |=> ($stable(tmask) && $stable(hmask)));

endmodule

// File: rtl/irqr_irq_merge.sv
module irqr_irq_merge #(
  parameter int N_TMR = 8,
  parameter int N_HW  = 8,
  parameter int N_OUT = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_TMR-1:0]            tmr_stat,
  input  logic [N_HW-1:0]             hw_irq,
  input  logic [N_OUT-1:0][N_TMR-1:0] tmask_all,
  input  logic [N_OUT-1:0][N_HW-1:0]  hmask_all,
  output logic [N_OUT-1:0]            irq
);

  for (genvar k = 0; k < N_OUT; k++) begin : g_line
    logic t_hit, h_hit;
    assign t_hit  = |(tmr_stat & tmask_all[k]);
    assign h_hit  = |(hw_irq & hmask_all[k]);
    assign irq[k] = t_hit | h_hit;

    p_quiet_when_masked_r8: assert property (@(posedge clk) disable iff (rst)
      (tmask_all[k] == '0 && hmask_all[k] == '0) |-> !irq[k]);

    p_hw_source_seen_r8: assert property (@(posedge clk) disable iff (rst)
      ((hw_irq & hmask_all[k]) != '0) |-> irq[k]);
  end

endmodule

// File: rtl/irqr_read_port.sv
module irqr_read_port
  import irqr_pkg::*;
#(
  parameter int N_TMR  = 8,
  parameter int N_HW   = 8,
  parameter int N_OUT  = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_en,
  input  logic [FN_W-1:0]             fn,
  input  logic                        idx_ok,
  input  logic [IDX_W-1:0]            idx,
  input  logic [N_TMR-1:0]            tmr_stat,
  input  logic [N_OUT-1:0][N_TMR-1:0] tmask_all,
  input  logic [N_OUT-1:0][N_HW-1:0]  hmask_all,
  output logic [DATA_W-1:0]           rdata
);

  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (idx_ok) begin
      case (fn)
        FN_TMASK: sel = DATA_W'(tmask_all[idx]);
        FN_TACT:  sel = DATA_W'(tmr_stat & tmask_all[idx]);
        FN_HMASK: sel = DATA_W'(hmask_all[idx]);
        default:  sel = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel;
    else            rdata <= '0;
  end

  p_alias_reads_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (fn == FN_TSET || fn == FN_TCLR)) |=> (rdata == '0));

  p_idle_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));

  p_bad_line_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !idx_ok) |=> (rdata == '0));

endmodule

// File: rtl/irq_mask_router.sv
module irq_mask_router
  import irqr_pkg::*;
#(
  parameter  int N_TMR  = 8,
  parameter  int N_HW   = 8,
  parameter  int N_OUT  = 4,
  parameter  int DATA_W = 32,
  localparam int IDX_W  = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int ADDR_W = FN_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [N_TMR-1:0]  tmr_stat,
  input  logic [N_HW-1:0]   hw_irq,
  output logic [N_OUT-1:0]  irq
);

  logic [FN_W-1:0]             fn;
  logic [IDX_W-1:0]            idx;
  logic                        idx_ok;
  logic [N_OUT-1:0][N_TMR-1:0] tmask_all;
  logic [N_OUT-1:0][N_HW-1:0]  hmask_all;
  logic                        unused_wdata;

  assign fn           = addr[ADDR_W-1 -: FN_W];
  assign idx          = addr[IDX_W-1:0];
  assign idx_ok       = (32'(idx) < N_OUT);
  assign unused_wdata = ^wdata;

  for (genvar k = 0; k < N_OUT; k++) begin : g_bank
    logic wr_sel;
    assign wr_sel = wr_en && idx_ok && (32'(idx) == k);

    irqr_mask_bank #(
      .N_TMR (N_TMR),
      .N_HW  (N_HW)
    ) u_bank (
      .clk    (clk),
      .rst    (rst),
      .wr_sel (wr_sel),
      .fn     (fn),
      .wt     (wdata[N_TMR-1:0]),
      .wh     (wdata[N_HW-1:0]),
      .tmask  (tmask_all[k]),
      .hmask  (hmask_all[k])
    );
  end

  irqr_irq_merge #(
    .N_TMR (N_TMR),
    .N_HW  (N_HW),
    .N_OUT (N_OUT)
  ) u_merge (
    .clk       (clk),
    .rst       (rst),
    .tmr_stat  (tmr_stat),
    .hw_irq    (hw_irq),
    .tmask_all (tmask_all),
    .hmask_all (hmask_all),
    .irq       (irq)
  );

  irqr_read_port #(
    .N_TMR  (N_TMR),
    .N_HW   (N_HW),
    .N_OUT  (N_OUT),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .fn        (fn),
    .idx_ok    (idx_ok),
    .idx       (idx),
    .tmr_stat  (tmr_stat),
    .tmask_all (tmask_all),
    .hmask_all (hmask_all),
    .rdata     (rdata)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (irq == '0));

endmodule

// File: tb/irq_mask_router_bench.sv
module irq_mask_router_bench;
  localparam int CLK_P  = 10;
  localparam int NT     = 12;
  localparam int NH     = 5;
  localparam int NO     = 3;
  localparam int DW     = 16;
  localparam int AW     = 5;

  logic          clk = 0;
  logic          rst = 1;
  logic          wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NT-1:0] tmr_stat = '0;
  logic [NH-1:0] hw_irq = '0;
  logic [NO-1:0] irq;

  logic [NT-1:0] mt [NO];
  logic [NH-1:0] mh [NO];
  int vec = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_mask_router #(.N_TMR(NT), .N_HW(NH), .N_OUT(NO), .DATA_W(DW)) u_irq_mask_router (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tmr_stat(tmr_stat), .hw_irq(hw_irq), .irq(irq)
  );

  function automatic logic [DW-1:0] exp_read(input int fn, input int ix);
    if (ix >= NO) return '0;
    case (fn)
      0: return DW'(mt[ix]);
      3: return DW'(tmr_stat & mt[ix]);
      4: return DW'(mh[ix]);
      default: return '0;
    endcase
  endfunction

  function automatic logic [NO-1:0] exp_irq();
    logic [NO-1:0] r;
    for (int k = 0; k < NO; k++) r[k] = |(tmr_stat & mt[k]) | |(hw_irq & mh[k]);
    return r;
  endfunction

  function automatic string req_of(input int fn);
    case (fn)
      0: return "R2";
      1, 2: return "R5";
      3: return "R6";
      4: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] ex);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, ex);
    end
  endtask

  task automatic model_write(input int fn, input int ix, input logic [DW-1:0] d);
    if (ix < NO) begin
      case (fn)
        0: mt[ix] = d[NT-1:0];
        1: mt[ix] = mt[ix] | d[NT-1:0];
        2: mt[ix] = mt[ix] & ~d[NT-1:0];
        4: mh[ix] = d[NH-1:0];
        default: ;
      endcase
    end
  endtask

  task automatic chk_irq(input string req);
    logic [NO-1:0] e;
    e = exp_irq();
    check(irq == e, req, DW'(irq), DW'(e));
  endtask

  task automatic do_wr(input int fn, input int ix, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; addr = {3'(fn), 2'(ix)}; wdata = d;
    #1 chk_irq("R9");
    @(negedge clk);
    wr_en = 0;
    model_write(fn, ix, d);
    chk_irq("R8");
  endtask

  task automatic do_rd(input int fn, input int ix, input string req);
    logic [DW-1:0] e;
    @(negedge clk);
    rd_en = 1; addr = {3'(fn), 2'(ix)};
    e = exp_read(fn, ix);
    @(negedge clk);
    rd_en = 0;
    check(rdata == e, req, rdata, e);
  endtask

  task automatic set_in(input logic [NT-1:0] t, input logic [NH-1:0] h);
    @(negedge clk);
    tmr_stat = t; hw_irq = h;
    #1 chk_irq("R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] old;
    void'($urandom(32'd20241));
    for (int k = 0; k < NO; k++) begin mt[k] = '0; mh[k] = '0; end
    tmr_stat = '1; hw_irq = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check(irq == '0, "R1", DW'(irq), '0);
    check(rdata == '0, "R1", rdata, '0);
    do_rd(0, 1, "R1");
    do_rd(4, 2, "R1");

    // R2 truncation and replace
    do_wr(0, 0, 16'hFFFF);
    do_rd(0, 0, "R2");
    do_wr(0, 0, 16'h0A50);
    do_rd(0, 0, "R2");
    // R3 / R4 aliases
    do_wr(0, 1, 16'h0003);
    do_wr(1, 1, 16'h0300);
    do_rd(0, 1, "R3");
    do_wr(2, 1, 16'hF001);
    do_rd(0, 1, "R4");
    do_rd(1, 1, "R5");
    do_rd(2, 1, "R5");
    // R6 active view and ignored write
    set_in(12'h30F, 5'h00);
    do_rd(3, 1, "R6");
    do_wr(3, 1, 16'hFFFF);
    do_rd(0, 1, "R6");
    // R7 hardware mask isolation
    do_wr(4, 2, 16'hFFF5);
    do_rd(4, 2, "R7");
    do_rd(0, 2, "R7");
    set_in(12'h000, 5'h04);
    set_in(12'h000, 5'h02);
    // R10 bad line, bad code, idle
    do_wr(0, 3, 16'h0FFF);
    do_rd(0, 3, "R10");
    do_wr(5, 0, 16'hFFFF);
    do_rd(5, 0, "R10");
    do_rd(0, 0, "R10");
    @(negedge clk);
    check(rdata == '0, "R10", rdata, '0);
    // R11 read and write in one cycle
    old = exp_read(0, 1);
    @(negedge clk);
    wr_en = 1; rd_en = 1; addr = {3'd0, 2'd1}; wdata = 16'h0777;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    check(rdata == old, "R11", rdata, old);
    model_write(0, 1, 16'h0777);
    do_rd(0, 1, "R11");

    for (int i = 0; i < 400; i++) begin
      int op, fn, ix;
      op = $urandom_range(0, 2);
      fn = $urandom_range(0, 7);
      ix = $urandom_range(0, 3);
      if (op == 0) do_wr(fn, ix, 16'($urandom));
      else if (op == 1) do_rd(fn, ix, req_of(fn));
      else set_in(NT'($urandom), NH'($urandom));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule